// File: doc/BRIEF.md
# Slow-Clock System Timer with Alarm

This block is a small system timer that runs on a 32768 Hz slow clock and is reached through a single-cycle register bus. A programmable prescaler divides the slow clock down to a tick. Each tick advances a free-running wrapping real-time counter. An absolute alarm compares the counter against a stored value. A separate periodic interval timer counts slow-clock cycles and flags every time its period elapses, and it needs no reload from software.

All events land in one sticky status register. Reading that register returns the flags and clears them, but an event that arrives in the same cycle as the read is kept. An interrupt mask is built up through two write-only ports: one sets mask bits and the other clears them. The mask can be read back at its own address. The interrupt output is high while any flag that is set has its mask bit set. A watchdog overflow flag has a reserved status position, but the watchdog itself is not modelled.

Top module: `sclk_timer`

## Requirements
- R1: The real-time counter is CNT_W bits wide (20 by default) and wraps from all-ones to zero.
- R2: With prescale value P, the counter advances once every P clock cycles, counted from the cycle after the prescale write. A value of 0 divides by 2^PRE_W. Writing the prescale register clears both the divider and the counter to zero.
- R3: After reset the prescale register reads 32768 (one tick per second). The period, alarm, counter, status and mask all read zero, and the interrupt output is low.
- R4: Status bit 3 (alarm) sets on the tick at which the counter steps onto the alarm value.
- R5: The alarm is checked only when the counter changes. An alarm equal to the counter's present value therefore fires only after a full wrap of 2^CNT_W ticks.
- R6: With period value N ≠ 0, status bit 0 sets every N cycles, counted from the cycle after the period write, and keeps doing so without a reload. A period of 0 stops the periodic timer.
- R7: Status bit 2 (counter increment) sets on every tick.
- R8: Status bit 1 (watchdog overflow) is reserved and always reads zero.
- R9: A status read returns the flags and clears them. A flag that sets in the same cycle as the read is kept.
- R10: Writing 1s to the enable port sets those mask bits. Writing 1s to the disable port clears them. The mask reads back at its own address.
- R11: The interrupt output equals the OR over bits of status AND mask.
- R12: Register addresses are: 0 prescale (rw), 1 period (rw), 2 alarm (rw), 3 counter (ro), 4 status (ro, clear on read), 5 enable (wo), 6 disable (wo), 7 mask (ro). Status and mask occupy the low four data bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow clock; also clocks the register bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd | input | 1 | Read strobe; a read of status clears it at the next edge |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DW (20) | Write data |
| bus_rdata | output | DW (20) | Read data, combinational from the address |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions assume that read and write strobes are never raised together, and that each strobe carries a stable address for the whole cycle. The bench drives only one bus operation per cycle, and each operation starts half a clock before the edge that takes it. The assertions also assume that the alarm and counter are compared on the same tick only when no prescale write is in flight. The bench never writes the alarm while a tick could land on that edge, because it freezes or restarts the prescaler first. Counts in the bench are taken in edges from the last prescale or period write, and the expected values follow from that count by division and modulo arithmetic.

// File: rtl/sclk_timer.sv
module sclk_timer #(
  parameter int CNT_W   = 20,
  parameter int PRE_W   = 16,
  parameter int PER_W   = 16,
  parameter int DW      = 20,
  parameter int PRE_RST = 32768
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam logic [2:0] A_PRE = 3'd0, A_PER = 3'd1, A_ALM = 3'd2, A_CNT = 3'd3,
                         A_STS = 3'd4, A_EN  = 3'd5, A_DIS = 3'd6, A_MSK = 3'd7;

  logic [PRE_W-1:0] pre_val, pre_cnt;
  logic [PER_W-1:0] per_val, per_cnt;
  logic [CNT_W-1:0] rtc, alm, rtc_nxt;
  logic [3:0]       sts, ien, evt;
  logic             wr_pre, wr_per, rd_sts, tick, pit_hit, alm_hit;

  assign wr_pre  = bus_wr && bus_addr == A_PRE;
  assign wr_per  = bus_wr && bus_addr == A_PER;
  assign rd_sts  = bus_rd && bus_addr == A_STS;
  assign tick    = pre_cnt == pre_val - 1'b1;
  assign rtc_nxt = rtc + 1'b1;
  assign alm_hit = tick && !wr_pre && rtc_nxt == alm;
  assign pit_hit = per_val != '0 && per_cnt == per_val - 1'b1 && !wr_per;
  assign evt     = {alm_hit, tick && !wr_pre, 1'b0, pit_hit};
  assign irq     = |(sts & ien);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_val <= PRE_W'(PRE_RST);
      pre_cnt <= '0;
      rtc     <= '0;
    end else if (wr_pre) begin
      pre_val <= bus_wdata[PRE_W-1:0];
      pre_cnt <= '0;
      rtc     <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
      rtc     <= rtc_nxt;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      per_val <= '0;
      per_cnt <= '0;
    end else if (wr_per) begin
      per_val <= bus_wdata[PER_W-1:0];
      per_cnt <= '0;
    end else if (pit_hit || per_val == '0) begin
      per_cnt <= '0;
    end else begin
      per_cnt <= per_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                           alm <= '0;
    else if (bus_wr && bus_addr == A_ALM) alm <= bus_wdata[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sts <= '0;
    else        sts <= (rd_sts ? 4'b0 : sts) | evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                           ien <= '0;
    else if (bus_wr && bus_addr == A_EN)  ien <= ien | bus_wdata[3:0];
    else if (bus_wr && bus_addr == A_DIS) ien <= ien & ~bus_wdata[3:0];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_PRE:   bus_rdata = DW'(pre_val);
      A_PER:   bus_rdata = DW'(per_val);
      A_ALM:   bus_rdata = DW'(alm);
      A_CNT:   bus_rdata = DW'(rtc);
      A_STS:   bus_rdata = DW'(sts);
      A_MSK:   bus_rdata = DW'(ien);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sclk_timer_chk.sv
module sclk_timer_chk #(
  parameter int CNT_W = 20,
  parameter int DW    = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_pre,
  input logic             rd_sts,
  input logic [CNT_W-1:0] rtc,
  input logic [CNT_W-1:0] alm,
  input logic [3:0]       sts,
  input logic [3:0]       ien,
  input logic [3:0]       evt,
  input logic             irq,
  input logic             bus_wr,
  input logic [2:0]       bus_addr,
  input logic [DW-1:0]    bus_wdata
);
  a_r2_pre_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pre |=> rtc == '0);
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_pre) |=> $stable(rtc));
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_pre && rtc == '1) |=> rtc == '0);
  a_r4_alarm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_pre && CNT_W'(rtc + 1'b1) == alm) |=> sts[3]);
  a_r7_inc_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_pre) |=> sts[2]);
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sts && evt == 4'b0) |=> sts == 4'b0);
  a_r10_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd5) |=> (ien & $past(bus_wdata[3:0])) == $past(bus_wdata[3:0]));
  a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd6) |=> (ien & $past(bus_wdata[3:0])) == 4'b0);
  a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ien == 4'b0 |-> !irq);
endmodule

bind sclk_timer sclk_timer_chk #(.CNT_W(CNT_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_pre(wr_pre), .rd_sts(rd_sts),
  .rtc(rtc), .alm(alm), .sts(sts), .ien(ien), .evt(evt), .irq(irq),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/sclk_timer_tb_top.sv
module sclk_timer_tb_top;
  localparam int CW = 8;
  localparam int DW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_rd, bus_wr;
  logic [2:0]    bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          irq;
  int            n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  sclk_timer #(.CNT_W(CW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = DW'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    bus_rd = 1'b1; bus_addr = 3'(a);
    #1 v = int'(bus_rdata);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int v;
    rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3: reset state, counted in edges from reset release
    rd(4, v); check("R3 status", v, 0);
    rd(7, v); check("R3 mask", v, 0);
    rd(0, v); check("R3 prescale", v, 32768);
    rd(3, v); check("R3 counter", v, 0);
    check("R3 irq", int'(irq), 0);
    idle(32763);
    rd(3, v); check("R3 counter before first second", v, 0);
    rd(3, v); check("R3 counter after first second", v, 1);
    rd(4, v); check("R7 increment flag", v, 4);

    // R2: prescale sweep
    for (int p = 1; p <= 4; p++) begin
      wr(0, p);
      for (int k = 0; k <= 3 * p; k++) begin
        rd(3, v); check("R2 prescale count", v, (k / p) % (1 << CW));
      end
    end
    // R1: wrap
    wr(0, 1); idle(258);
    rd(3, v); check("R1 wrap", v, 258 % (1 << CW));
    // R2: value 0 divides by 2^PRE_W
    wr(0, 0); idle(100);
    rd(3, v); check("R2 zero prescale holds", v, 0);

    // R4/R7/R8: alarm at 5
    wr(2, 5); wr(0, 1); rd(4, v);
    for (int k = 1; k <= 8; k++) begin
      rd(4, v);
      check("R4 alarm flag", (v >> 3) & 1, (k == 5) ? 1 : 0);
      check("R7 tick flag", (v >> 2) & 1, 1);
      check("R8 watchdog bit", (v >> 1) & 1, 0);
    end

    // R5: alarm equal to current counter waits a full wrap
    wr(0, 4); wr(2, 0); rd(4, v); wr(5, 8);
    check("R5 no immediate match", int'(irq), 0);
    idle(1020);
    check("R5 no match before wrap", int'(irq), 0);
    idle(1);
    check("R5 match after wrap", int'(irq), 1);
    wr(6, 8);
    check("R11 irq masked off", int'(irq), 0);

    // R10/R11: mask set and clear
    wr(5, 5); rd(7, v); check("R10 enable", v, 5);
    wr(6, 1); rd(7, v); check("R10 disable", v, 4);
    idle(8);
    check("R11 irq from increment", int'(irq), 1);
    wr(6, 4);
    check("R11 irq with empty mask", int'(irq), 0);
    rd(4, v); check("R11 status kept while masked", (v >> 2) & 1, 1);

    // R6/R9: periodic sweep; reads every cycle, new event survives clear
    wr(0, 0);
    for (int p = 1; p <= 5; p++) begin
      wr(1, p); rd(4, v);
      for (int k = 1; k <= 3 * p; k++) begin
        rd(4, v); check("R6 period flag", v & 1, (k % p == 0) ? 1 : 0);
      end
    end
    wr(1, 0); rd(4, v);
    for (int k = 0; k < 10; k++) begin
      rd(4, v); check("R6 period off", v & 1, 0);
    end
    rd(1, v); check("R12 period readback", v, 0);

    // R9: clear on read
    wr(1, 3); idle(5); wr(1, 0);
    rd(4, v); check("R9 flag before clear", v & 1, 1);
    rd(4, v); check("R9 cleared", v, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule